// File: doc/BRIEF.md
# Predicated Ordered Floating-Point Reduction

This unit folds the active lanes of one packed vector into a scalar floating-point accumulator. The accumulator is loaded from the scalar input when a job is accepted. The unit then walks the lanes from index 0 upward and performs one IEEE-754 addition per clock. Each addition takes the running sum as its first operand and the current lane as its second. Lanes whose governing predicate bit is clear are skipped. When the walk ends, the final sum replaces the scalar, and a one-cycle completion pulse marks it valid.

A 2-bit size code selects the element format: half, single or double precision. A vector of `VLEN` bits therefore holds 16, 8 or 4 lanes at the default length of 256 bits. The predicate carries one bit per vector byte. Because the additions are strictly serial, the rounding of every intermediate sum is visible in the result, and a tree reduction would not be equivalent. The internal adder rounds to nearest, ties to even. It handles subnormals, infinities and NaNs, and it raises no exception flags.

Top module: `fp_ordered_sum`

## Requirements
- R1: When a job is accepted (`start_i` high while `ready_o` is high), the accumulator takes the value of `scalar_i`. The final sum appears on `result_o` in the cycle `done_o` is high.
- R2: Active lanes are added strictly in ascending lane order. Each addition is rounded, with the running sum as the first operand. For example, in single precision, 2^24 + 1 + 1 − 2^24 in that order yields +0.
- R3: Size code 01 selects 16-bit half, 10 selects 32-bit single and 11 selects 64-bit double elements. Lane e of width w occupies vector bits [e*w+w-1 : e*w], and the lane count is VLEN/w.
- R4: Size code 00 is illegal. On acceptance, `done_o` pulses after the accepting edge with `undef_o` high, and `result_o` equals `scalar_i` bit for bit.
- R5: Lane e takes part only when predicate bit e*(w/8) is set. The other predicate bits and the inactive lane contents have no effect on the result.
- R6: With no active lane, the result equals the low w bits of the initial scalar.
- R7: Each addition rounds to nearest, ties to even. Results that exceed the largest finite value become infinity of the same sign. Subnormal operands and results are exact where representable. An exact zero sum of opposite-signed operands is +0.
- R8: A NaN operand yields that NaN with its most significant fraction bit set, with the running sum taking precedence. Infinity plus opposite-signed infinity yields the default NaN: sign 0, exponent all ones, only the top fraction bit set (0x7E00 for half, 0x7FF8000000000000 for double).
- R9: After reset, `ready_o` is high, `done_o` is low and `result_o` is zero. For a legal size, `ready_o` is low from the cycle after acceptance until `done_o`. `done_o` is high for one cycle exactly VLEN/w cycles after the accepting edge, with `ready_o` high in that cycle.
- R10: `start_i` is ignored while the unit is busy. Neither the result nor the timing of the running job changes.
- R11: For 16- and 32-bit elements, the bits of `result_o` above the element width are zero at completion, whatever the upper bits of `scalar_i` held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a reduction |
| ready_o | output | 1 | High when a new job can be accepted |
| done_o | output | 1 | One-cycle completion pulse |
| undef_o | output | 1 | The last accepted job used the illegal size code |
| size_i | input | 2 | Element size code |
| scalar_i | input | 64 | Initial accumulator value (low bits for narrow formats) |
| vec_i | input | VLEN | Packed vector operand |
| pred_i | input | VLEN/8 | Predicate, one bit per vector byte |
| result_o | output | 64 | Accumulated result |

## Verification
The bench sweeps all three formats with random lane values and predicates. For half and single precision it uses integer-valued operands, whose exact sums it encodes itself. For double precision it uses native double arithmetic evaluated lane by lane, so a design that reordered the additions or misplaced a guard or sticky bit would drift in the last place. Directed cases target the following, each with the failure it would expose:
- A tie that must round to even in both directions, which a design that rounds ties up would fail.
- A cancellation that only the serial order produces (R2), which a tree or reversed walk would miss.
- Overflow to infinity, which a design that saturates would miss.
- Subnormals that carry into the normal range, which a design that loses the hidden bit would miss.
- Infinity minus infinity, which must give the default NaN.
- Signalling NaN quieting.

The remaining checks cover the following, each with the failure it would expose:
- Predicates with garbage in the non-governing bits, which catch a unit that indexes the predicate per lane instead of per byte.
- Garbage in the upper scalar bits, which catch a unit that leaks stale bits.
- The illegal size code, which must leave the scalar untouched.
- A start pulse injected mid-job, which would restart or corrupt a unit that does not gate it.

// File: rtl/fp_ordered_sum.sv
module fp_ordered_sum #(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              undef_o,
  input  logic [1:0]        size_i,
  input  logic [63:0]       scalar_i,
  input  logic [VLEN-1:0]   vec_i,
  input  logic [VLEN/8-1:0] pred_i,
  output logic [63:0]       result_o
);
  localparam int PW  = VLEN / 8;
  localparam int LW  = $clog2(VLEN / 16 + 1);
  localparam int PIW = $clog2(PW);

  logic            busy, done_q, undef_q;
  logic [1:0]      sz_q;
  logic [63:0]     acc, elem, sum;
  logic [VLEN-1:0] vec_q;
  logic [PW-1:0]   pred_q;
  logic [LW-1:0]   idx;
  logic [PIW-1:0]  pidx;
  logic            act, last;

  function automatic logic [63:0] wmask(input logic [1:0] sz);
    case (sz)
      2'b01:   return 64'h0000_0000_0000_FFFF;
      2'b10:   return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  function automatic logic [63:0] fadd(input logic [63:0] a, input logic [63:0] b,
                                       input logic [1:0] sz);
    int          ew, mw, lp;
    logic [11:0] emax, ea, eb, et, d;
    logic [12:0] e;
    logic [63:0] fmask, qbit, fa, fb, ta, tb, r;
    logic [57:0] ma, mb, mt, m, lowm;
    logic        sa, sb, st, nan_a, nan_b, inf_a, inf_b, gb, stk;
    case (sz)
      2'b01:   begin ew = 5;  mw = 10; end
      2'b10:   begin ew = 8;  mw = 23; end
      default: begin ew = 11; mw = 52; end
    endcase
    lp    = 55 - mw;
    emax  = 12'((1 << ew) - 1);
    fmask = (64'd1 << mw) - 64'd1;
    qbit  = 64'd1 << (mw - 1);
    ta = a >> mw;
    tb = b >> mw;
    ea = ta[11:0] & emax;
    eb = tb[11:0] & emax;
    fa = a & fmask;
    fb = b & fmask;
    sa = a[ew+mw];
    sb = b[ew+mw];
    nan_a = (ea == emax) && (fa != 0);
    nan_b = (eb == emax) && (fb != 0);
    inf_a = (ea == emax) && (fa == 0);
    inf_b = (eb == emax) && (fb == 0);
    r = '0;
    if (nan_a) r = a | qbit;
    else if (nan_b) r = b | qbit;
    else if (inf_a && inf_b && (sa != sb)) r = ({52'd0, emax} << mw) | qbit;
    else if (inf_a) r = a;
    else if (inf_b) r = b;
    else begin
      ma = 58'(fa) << lp;
      mb = 58'(fb) << lp;
      if (ea != 0) ma[55] = 1'b1; else ea = 12'd1;
      if (eb != 0) mb[55] = 1'b1; else eb = 12'd1;
      if ({eb, mb} > {ea, ma}) begin
        et = ea; ea = eb; eb = et;
        mt = ma; ma = mb; mb = mt;
        st = sa; sa = sb; sb = st;
      end
      d = ea - eb;
      if (d > 12'd57) mb = {57'd0, |mb};
      else begin
        lowm  = (58'd1 << d) - 58'd1;
        stk   = |(mb & lowm);
        mb    = mb >> d;
        mb[0] = mb[0] | stk;
      end
      m = (sa == sb) ? ma + mb : ma - mb;
      e = {1'b0, ea};
      if (m == 0) r = 64'(sa & sb) << (ew + mw);
      else begin
        if (m[56]) begin
          m = {1'b0, m[57:2], m[1] | m[0]};
          e = e + 13'd1;
        end
        for (int i = 0; i < 56; i++)
          if (!m[55] && e > 13'd1) begin
            m = m << 1;
            e = e - 13'd1;
          end
        gb  = m[lp-1];
        stk = |(m & ((58'd1 << (lp - 1)) - 58'd1));
        if (gb && (stk || m[lp])) m = m + (58'd1 << lp);
        m = m & ~((58'd1 << lp) - 58'd1);
        if (m[56]) begin
          m = m >> 1;
          e = e + 13'd1;
        end
        if (!m[55]) e = '0;
        if (e >= {1'b0, emax})
          r = (64'(sa) << (ew + mw)) | ({52'd0, emax} << mw);
        else
          r = (64'(sa) << (ew + mw)) | (64'(e) << mw) | (64'(m >> lp) & fmask);
      end
    end
    return r;
  endfunction

  assign elem = 64'(vec_q >> (32'(idx) << (3 + sz_q))) & wmask(sz_q);
  assign pidx = PIW'(32'(idx) << sz_q);
  assign act  = pred_q[pidx];
  assign last = 32'(idx) == (VLEN >> (3 + sz_q)) - 1;
  assign sum  = fadd(acc, elem, sz_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      sz_q    <= 2'b11;
      acc     <= '0;
      vec_q   <= '0;
      pred_q  <= '0;
      idx     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy && start_i) begin
        sz_q    <= size_i;
        undef_q <= size_i == 2'b00;
        vec_q   <= vec_i;
        pred_q  <= pred_i;
        idx     <= '0;
        if (size_i == 2'b00) begin
          acc    <= scalar_i;
          done_q <= 1'b1;
        end else begin
          acc  <= scalar_i & wmask(size_i);
          busy <= 1'b1;
        end
      end else if (busy) begin
        if (act) acc <= sum;
        idx <= idx + 1'b1;
        if (last) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign ready_o  = !busy;
  assign done_o   = done_q;
  assign undef_o  = undef_q;
  assign result_o = acc;
endmodule

// File: rtl/fp_ordered_sum_chk.sv
module fp_ordered_sum_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        ready_o,
  input logic        done_o,
  input logic        undef_o,
  input logic [63:0] scalar_i,
  input logic [63:0] result_o,
  input logic [1:0]  sz_q
);
  a_r9_ready_falls_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_o) |-> $past(start_i));

  a_r9_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ready_o);

  a_r4_undef_keeps_scalar: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && undef_o) |-> result_o == $past(scalar_i));

  a_r11_upper_zero_half: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !undef_o && sz_q == 2'b01) |-> result_o[63:16] == '0);

  a_r11_upper_zero_single: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !undef_o && sz_q == 2'b10) |-> result_o[63:32] == '0);

  a_r10_size_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |=> (ready_o || $stable(sz_q)));

  a_r9_legal_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !undef_o) |-> $past(!ready_o));
endmodule

bind fp_ordered_sum fp_ordered_sum_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_o(ready_o),
  .done_o(done_o), .undef_o(undef_o), .scalar_i(scalar_i),
  .result_o(result_o), .sz_q(sz_q)
);

// File: tb/fp_ordered_sum_bench.sv
module fp_ordered_sum_bench;
  localparam int VLEN = 256;
  localparam int PW   = VLEN / 8;

  logic            clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic            ready_o, done_o, undef_o;
  logic [1:0]      size_i = '0;
  logic [63:0]     scalar_i = '0, result_o;
  logic [VLEN-1:0] vec_i = '0;
  logic [PW-1:0]   pred_i = '0;
  int nchk = 0, nbad = 0;
  bit finished = 0;

  fp_ordered_sum #(.VLEN(VLEN)) u_fp_ordered_sum (.*);

  always #2.5 clk = ~clk;

  initial begin
    #1000000;
    if (!finished) begin
      nchk++; nbad++;
      $display("FAIL watchdog: run hung act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] wm(input logic [1:0] sz);
    return (sz == 2'b01) ? 64'hFFFF : (sz == 2'b10) ? 64'hFFFF_FFFF : '1;
  endfunction

  function automatic logic [63:0] enc(input longint v, input int ew, input int mw);
    longint a;
    int p;
    logic [63:0] fr;
    if (v == 0) return '0;
    a = (v < 0) ? -v : v;
    p = 0;
    for (int i = 0; i < 62; i++) if ((a >> i) != 0) p = i;
    fr = (p <= mw) ? 64'(a) << (mw - p) : 64'(a) >> (p - mw);
    fr = fr & ((64'd1 << mw) - 1);
    return (64'(v < 0) << (ew + mw)) | (64'((1 << (ew - 1)) - 1 + p) << mw) | fr;
  endfunction

  function automatic logic [VLEN-1:0] put(input logic [VLEN-1:0] v, input int e,
                                          input int esz, input logic [63:0] x);
    logic [VLEN-1:0] w;
    w = {{(VLEN-64){1'b0}}, x & wm(2'(esz / 32 + 1 + (esz == 64 ? 0 : 0)))};
    if (esz == 16) w = {{(VLEN-64){1'b0}}, x & 64'hFFFF};
    return v | (w << (e * esz));
  endfunction

  function automatic logic [63:0] rdbl();
    return {1'($urandom), 11'(1000 + $urandom % 47), 20'($urandom), 32'($urandom)};
  endfunction

  task automatic run(input logic [1:0] sz, input logic [63:0] sc, input logic [VLEN-1:0] v,
                     input logic [PW-1:0] p, input bit poke, output logic [63:0] res,
                     output int lat, output logic rdy0, output logic rdyd, output logic und);
    @(negedge clk);
    size_i = sz; scalar_i = sc; vec_i = v; pred_i = p; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    rdy0 = ready_o;
    lat = 0;
    while (!done_o && lat < 100) begin
      if (poke && lat == 1) begin
        start_i = 1'b1; scalar_i = ~sc; size_i = 2'b00; vec_i = ~v;
      end else start_i = 1'b0;
      @(negedge clk);
      lat++;
    end
    start_i = 1'b0;
    res = result_o; rdyd = ready_o; und = undef_o;
  endtask

  task automatic dir(input string tag, input logic [1:0] sz, input logic [63:0] sc,
                     input logic [63:0] l0, input logic [63:0] l1, input logic [63:0] l2,
                     input logic [2:0] act, input logic [63:0] exp);
    logic [VLEN-1:0] v;
    logic [PW-1:0] p;
    logic [63:0] res;
    int lat, esz;
    logic r0, rd, u;
    esz = 8 << sz;
    v = put(put(put('0, 0, esz, l0), 1, esz, l1), 2, esz, l2);
    p = '0;
    for (int e = 0; e < 3; e++) p[e << sz] = act[e];
    run(sz, sc, v, p, 1'b0, res, lat, r0, rd, u);
    chk(tag, res, exp);
  endtask

  task automatic rnd(input logic [1:0] sz, input bit poke);
    int esz, nl, grp, lim;
    longint si, li, sum;
    logic [63:0] sc, ln, exp, res;
    logic [VLEN-1:0] v;
    logic [PW-1:0] p;
    real r;
    bit a;
    int lat;
    logic r0, rd, u;
    esz = 8 << sz; nl = VLEN / esz; grp = esz / 8;
    lim = (sz == 2'b01) ? 100 : 100000;
    v = '0; p = PW'({$urandom, $urandom});
    if (sz == 2'b11) begin
      sc = rdbl(); r = $bitstoreal(sc);
    end else begin
      si = longint'($urandom % (2 * lim + 1)) - lim; sum = si;
      sc = (enc(si, sz == 2'b01 ? 5 : 8, sz == 2'b01 ? 10 : 23) & wm(sz)) |
           ({$urandom, $urandom} & ~wm(sz));
    end
    for (int e = 0; e < nl; e++) begin
      a = 1'($urandom);
      p[e * grp] = a;
      if (sz == 2'b11) begin
        ln = rdbl();
        if (a) r = r + $bitstoreal(ln);
      end else begin
        li = longint'($urandom % (2 * lim + 1)) - lim;
        ln = enc(li, sz == 2'b01 ? 5 : 8, sz == 2'b01 ? 10 : 23);
        if (a) sum = sum + li;
      end
      v = put(v, e, esz, ln);
    end
    exp = (sz == 2'b11) ? $realtobits(r) : enc(sum, sz == 2'b01 ? 5 : 8, sz == 2'b01 ? 10 : 23);
    run(sz, sc, v, p, poke, res, lat, r0, rd, u);
    chk(poke ? "R10 result with start while busy" : "R1/R5 ordered predicated sum", res, exp);
    chk("R3 lane count latency", 64'(lat), 64'(nl));
    chk("R9 ready low while busy", {63'd0, r0}, 64'd0);
    chk("R9 ready high at done", {63'd0, rd}, 64'd1);
    chk("R4 undef low for legal size", {63'd0, u}, 64'd0);
    chk("R11 upper bits zero", res & ~wm(sz), 64'd0);
  endtask

  initial begin
    logic [63:0] res;
    int lat;
    logic r0, rd, u;
    logic [VLEN-1:0] gv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R9 reset ready", {63'd0, ready_o}, 64'd1);
    chk("R9 reset done", {63'd0, done_o}, 64'd0);
    chk("R9 reset result", result_o, 64'd0);

    run(2'b00, 64'h1234_5678_9ABC_DEF0, '1, '1, 1'b0, res, lat, r0, rd, u);
    chk("R4 illegal size keeps scalar", res, 64'h1234_5678_9ABC_DEF0);
    chk("R4 undef flag", {63'd0, u}, 64'd1);
    chk("R4 immediate completion", 64'(lat), 64'd0);

    gv = '0;
    for (int i = 0; i < VLEN / 32; i++) gv[i*32 +: 32] = 32'h3F80_0000;
    run(2'b10, 64'hDEAD_BEEF_4040_0000, gv, {8{4'b1110}}, 1'b0, res, lat, r0, rd, u);
    chk("R6 R5 no governing bit set", res, 64'h4040_0000);

    dir("R7 half tie stays even", 2'b01, 64'h6800, 64'h3C00, 0, 0, 3'b001, 64'h6800);
    dir("R7 half tie rounds up to even", 2'b01, 64'h6801, 64'h3C00, 0, 0, 3'b001, 64'h6802);
    dir("R7 single tie stays even", 2'b10, 64'h3F80_0000, 64'h3380_0000, 0, 0, 3'b001, 64'h3F80_0000);
    dir("R7 single above half ulp", 2'b10, 64'h3F80_0000, 64'h3440_0000, 0, 0, 3'b001, 64'h3F80_0002);
    dir("R7 half overflow to inf", 2'b01, 64'h7BFF, 64'h7BFF, 0, 0, 3'b001, 64'h7C00);
    dir("R7 half subnormals carry to normal", 2'b01, 64'h0200, 64'h0200, 64'h0001, 0, 3'b011, 64'h0401);
    dir("R7 exact cancel gives +0", 2'b01, 64'h3C00, 64'hBC00, 0, 0, 3'b001, 64'h0000);
    dir("R2 serial order cancellation", 2'b10, 64'h4B80_0000, 64'h3F80_0000, 64'h3F80_0000,
        64'hCB80_0000, 3'b111, 64'h0000_0000);
    dir("R8 half inf minus inf", 2'b01, 64'h7C00, 64'hFC00, 64'h3C00, 0, 3'b011, 64'h7E00);
    dir("R8 half signalling nan quieted", 2'b01, 64'h3C00, 64'h7D01, 64'h3C00, 0, 3'b011, 64'h7F01);
    dir("R8 scalar nan wins", 2'b01, 64'h7D02, 64'h7D01, 0, 0, 3'b001, 64'h7F02);
    dir("R8 double inf minus inf", 2'b11, 64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 0, 0,
        3'b001, 64'h7FF8_0000_0000_0000);
    dir("R8 double scalar nan", 2'b11, 64'h7FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000, 0, 0,
        3'b001, 64'h7FF8_0000_0000_0001);
    dir("R5 inactive lane ignored", 2'b11, 64'h3FF0_0000_0000_0000, 64'h7FF0_0000_0000_0001,
        64'h4000_0000_0000_0000, 0, 3'b010, 64'h4008_0000_0000_0000);

    for (int t = 0; t < 40; t++) rnd(2'b01, t % 8 == 3);
    for (int t = 0; t < 40; t++) rnd(2'b10, t % 8 == 3);
    for (int t = 0; t < 60; t++) rnd(2'b11, t % 8 == 3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule